// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home-node side of a memory-based coherence protocol with a full bit vector per block. Each memory block owned by this home has one directory entry that holds a state (Uncached, Shared or Exclusive) and one sharer bit per node. Requests come in one per cycle on a request port. Each carries a type, the requesting node and the block address, plus the block data for a write-back. The controller answers the requester on a reply channel. It sends invalidations, fetches and interventions to caches on a coherence channel, and it hands data recovered from an old owner to the requester on a forward channel. The memory array sits outside the block: reads are combinational through an address/data pair, and writes take effect at the clock edge.

When a miss hits a block that another cache holds Exclusive, the home must wait for that owner. In forwarding mode (`c2c_en` low) the owner returns the block to the home, and the home passes it on to the requester. That costs four network transfers. In cache-to-cache mode (`c2c_en` high) the home sends an intervention that names the requester. The owner ships the block straight to the requester and then reports back to the home, which costs three transfers. Only one such wait can be outstanding at a time. Requests that cannot be served receive a negative acknowledgement and must be retried by the requester.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry is Uncached (state 2'b00) with an empty sharer vector, and no output channel is valid. A write miss to any block after reset is answered with a data reply and no coherence message.
- R2: A read miss (type 2'b00) to an Uncached or Shared block gives a data reply one cycle later (rep_valid=1, rep_nak=0, rep_dst=requester). The reply carries the memory word read in the request cycle, and the entry becomes Shared (2'b01) with the requester added to its sharers.
- R3: A write miss (type 2'b01) to an Uncached block gives a data reply with the memory word, and the entry becomes Exclusive (2'b10) with only the requester as sharer.
- R4: A write miss to a Shared block gives a data reply to the requester. In the same cycle it sends one invalidate (coh_kind 3'd1) whose coh_mask is the sharer vector without the requester, and it sends no invalidate if that mask is empty. The entry then becomes Exclusive with only the requester.
- R5: In forwarding mode, a write miss to a block that another node owns Exclusive sends a fetch-invalidate (coh_kind 3'd3) to the owner only, with mask bit n meaning node n. The owner response's data then goes out on the forward channel to the requester. The entry becomes Exclusive for the requester only, and memory is not written.
- R6: In forwarding mode, a read miss to a block that another node owns sends a fetch (coh_kind 3'd2) to the owner. On the owner response, memory at that block is written with the response data and the data is forwarded to the requester. The entry becomes Shared with the owner and the requester.
- R7: In cache-to-cache mode, a miss to a block owned by another node sends an intervention (coh_kind 3'd5 for a write miss, 3'd4 for a read miss) to the owner, with coh_req naming the requester. The owner response completes the transaction with no forward-channel message. The entry and memory are updated as in R5 and R6.
- R8: While a transaction waits for an owner response, any request to that block gets a negative acknowledgement (rep_nak=1 to the requester) and changes neither the entry nor memory.
- R9: A second miss that needs an owner while one wait is outstanding is negatively acknowledged. So is any request presented in the cycle an owner response is taken. Requests to other blocks that need no owner are served normally during a wait.
- R10: A write-back (type 2'b10) from the current Exclusive owner writes the request data to memory in the request cycle, returns the entry to Uncached with no sharers, and sends no message. A write-back from any other node is ignored.
- R11: A read or write miss from the node that already owns the block Exclusive is negatively acknowledged. Type 2'b11 requests are ignored, and an owner response arriving with nothing pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| c2c_en | input | 1 | 1 selects cache-to-cache interventions, 0 selects forwarding through the home |
| req_valid | input | 1 | Request present this cycle |
| req_type | input | 2 | 00 read miss, 01 write miss, 10 write-back, 11 reserved |
| req_src | input | NODE_W | Requesting node |
| req_addr | input | ADDR_W | Block address |
| req_data | input | DATA_W | Block data for a write-back |
| rsp_valid | input | 1 | Response from the owner of the pending block |
| rsp_data | input | DATA_W | Block data returned by the owner |
| mem_raddr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Memory read data (combinational) |
| mem_we | output | 1 | Memory write enable, taken at the clock edge |
| mem_waddr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| rep_valid | output | 1 | Reply to a requester |
| rep_nak | output | 1 | Reply is a negative acknowledgement |
| rep_dst | output | NODE_W | Reply destination node |
| rep_data | output | DATA_W | Reply block data |
| coh_valid | output | 1 | Coherence message to caches |
| coh_kind | output | 3 | 1 invalidate, 2 fetch, 3 fetch-invalidate, 4 read intervention, 5 write intervention |
| coh_mask | output | NODES | Destination nodes, bit n for node n |
| coh_addr | output | ADDR_W | Block address of the coherence message |
| coh_req | output | NODE_W | Requester named in an intervention |
| fwd_valid | output | 1 | Owner data forwarded by the home |
| fwd_dst | output | NODE_W | Forward destination |
| fwd_addr | output | ADDR_W | Block address of the forwarded data |
| fwd_data | output | DATA_W | Forwarded block data |

## Verification
A wrong sharer vector shows up at the ports at the next write miss to that block, as an invalidate mask that names the wrong nodes. A wrong state shows up on the next request to the block as a data reply where an owner fetch or a negative acknowledgement was due, or the reverse. A missing or misplaced memory update shows up on the next read miss as a stale reply word. Because of this, the stimulus follows a block through every state transition and probes it on the very next cycle. It also compares the externally modelled memory against an independently computed image after every step. A stuck busy marker is exposed by a negative acknowledgement to a block that should be free, while a marker that was never set is exposed by a request being served during a wait.

// File: rtl/dir_pkg.sv
`timescale 1ns/1ps
package dir_pkg;
  typedef enum logic [1:0] {
    DIR_UNC = 2'b00,
    DIR_SHR = 2'b01,
    DIR_EXC = 2'b10
  } dir_state_e;

  typedef enum logic [1:0] {
    RQ_READ  = 2'b00,
    RQ_WRITE = 2'b01,
    RQ_WBACK = 2'b10,
    RQ_RSVD  = 2'b11
  } req_kind_e;

  // coherence channel message kinds
  localparam logic [2:0] CK_NONE      = 3'd0;
  localparam logic [2:0] CK_INV       = 3'd1;
  localparam logic [2:0] CK_FETCH     = 3'd2;
  localparam logic [2:0] CK_FETCH_INV = 3'd3;
  localparam logic [2:0] CK_INTV_RD   = 3'd4;
  localparam logic [2:0] CK_INTV_WR   = 3'd5;
endpackage

// File: rtl/dir_entry_store.sv
`timescale 1ns/1ps
module dir_entry_store
  import dir_pkg::*;
#(
  parameter int NODES = 8,
  parameter int NBLK  = 16,
  localparam int ADDR_W = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output dir_state_e        rd_state,
  output logic [NODES-1:0]  rd_sharers,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  dir_state_e        wr_state,
  input  logic [NODES-1:0]  wr_sharers
);
  dir_state_e       st_q [NBLK];
  logic [NODES-1:0] sh_q [NBLK];

  // R1: every entry starts Uncached with no sharers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) begin
        st_q[i] <= DIR_UNC;
        sh_q[i] <= '0;
      end
    end else if (wr_en) begin
      st_q[wr_addr] <= wr_state;
      sh_q[wr_addr] <= wr_sharers;
    end
  end

  assign rd_state   = st_q[rd_addr];
  assign rd_sharers = sh_q[rd_addr];
endmodule

// File: rtl/dir_pend_track.sv
`timescale 1ns/1ps
module dir_pend_track #(
  parameter int NODES = 8,
  parameter int NBLK  = 16,
  localparam int NODE_W = $clog2(NODES),
  localparam int ADDR_W = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic              clr,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic [NODE_W-1:0] set_req,
  input  logic [NODE_W-1:0] set_owner,
  input  logic              set_wr,
  input  logic              set_c2c,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic [NODE_W-1:0] req,
  output logic [NODE_W-1:0] owner,
  output logic              is_wr,
  output logic              c2c
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      addr  <= '0;
      req   <= '0;
      owner <= '0;
      is_wr <= 1'b0;
      c2c   <= 1'b0;
    end else if (set) begin
      busy  <= 1'b1;
      addr  <= set_addr;
      req   <= set_req;
      owner <= set_owner;
      is_wr <= set_wr;
      c2c   <= set_c2c;
    end else if (clr) begin
      busy  <= 1'b0;
    end
  end
endmodule

// File: rtl/dir_home_ctrl.sv
`timescale 1ns/1ps
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int NBLK   = 16,
  parameter int DATA_W = 32,
  localparam int NODE_W = $clog2(NODES),
  localparam int ADDR_W = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c2c_en,
  input  logic              req_valid,
  input  logic [1:0]        req_type,
  input  logic [NODE_W-1:0] req_src,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rep_valid,
  output logic              rep_nak,
  output logic [NODE_W-1:0] rep_dst,
  output logic [DATA_W-1:0] rep_data,
  output logic              coh_valid,
  output logic [2:0]        coh_kind,
  output logic [NODES-1:0]  coh_mask,
  output logic [ADDR_W-1:0] coh_addr,
  output logic [NODE_W-1:0] coh_req,
  output logic              fwd_valid,
  output logic [NODE_W-1:0] fwd_dst,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data
);
  // one-hot sharer bit for a node
  function automatic logic [NODES-1:0] node_bit(input logic [NODE_W-1:0] n);
    node_bit = '0;
    node_bit[n] = 1'b1;
  endfunction

  // lowest set bit of a sharer vector; the owner of an Exclusive entry
  function automatic logic [NODE_W-1:0] low_index(input logic [NODES-1:0] m);
    low_index = '0;
    for (int i = NODES - 1; i >= 0; i--)
      if (m[i]) low_index = NODE_W'(i);
  endfunction

  // directory entry read at the request address
  dir_state_e       cur_state;
  logic [NODES-1:0] cur_sharers;

  // entry write port
  logic             st_we;
  logic [ADDR_W-1:0] st_waddr;
  dir_state_e       st_wstate;
  logic [NODES-1:0] st_wsh;

  // pending transaction
  logic              pend_set, pend_clr, pend_busy, pend_wr, pend_c2c;
  logic [ADDR_W-1:0] pend_addr;
  logic [NODE_W-1:0] pend_req, pend_owner;

  dir_entry_store #(.NODES(NODES), .NBLK(NBLK)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(req_addr), .rd_state(cur_state), .rd_sharers(cur_sharers),
    .wr_en(st_we), .wr_addr(st_waddr), .wr_state(st_wstate), .wr_sharers(st_wsh)
  );

  // named internal events
  logic [NODES-1:0]  src_mask;
  logic [NODE_W-1:0] owner_idx;
  logic is_rd, is_wr, is_wb;
  logic owned_by_src, need_owner, blk_busy, rsp_take, nak, go;

  assign src_mask     = node_bit(req_src);
  assign owner_idx    = low_index(cur_sharers);
  assign is_rd        = (req_type == RQ_READ);
  assign is_wr        = (req_type == RQ_WRITE);
  assign is_wb        = (req_type == RQ_WBACK);
  assign owned_by_src = (cur_state == DIR_EXC) && (cur_sharers == src_mask);
  assign need_owner   = (is_rd || is_wr) && (cur_state == DIR_EXC) && !owned_by_src;
  assign blk_busy     = pend_busy && (pend_addr == req_addr);
  assign rsp_take     = rsp_valid && pend_busy;   // R11: stray response is dropped
  // R8, R9, R11: conditions that earn a negative acknowledgement
  assign nak = req_valid &&
               (((is_rd || is_wr) && (rsp_take || blk_busy || owned_by_src ||
                                      (need_owner && pend_busy))) ||
                (is_wb && (rsp_take || blk_busy)));
  assign go  = req_valid && !nak;

  dir_pend_track #(.NODES(NODES), .NBLK(NBLK)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set(pend_set), .clr(pend_clr),
    .set_addr(req_addr), .set_req(req_src), .set_owner(owner_idx),
    .set_wr(is_wr), .set_c2c(c2c_en),
    .busy(pend_busy), .addr(pend_addr), .req(pend_req), .owner(pend_owner),
    .is_wr(pend_wr), .c2c(pend_c2c)
  );

  // next values of the registered channels
  logic              rep_v_n, rep_nak_n, coh_v_n, fwd_v_n;
  logic [NODE_W-1:0] rep_dst_n, coh_req_n, fwd_dst_n;
  logic [DATA_W-1:0] rep_data_n, fwd_data_n;
  logic [2:0]        coh_kind_n;
  logic [NODES-1:0]  coh_mask_n, inv_mask;

  assign mem_raddr = req_addr;
  assign inv_mask  = cur_sharers & ~src_mask;

  always_comb begin
    st_we      = 1'b0;
    st_waddr   = req_addr;
    st_wstate  = DIR_UNC;
    st_wsh     = '0;
    pend_set   = 1'b0;
    pend_clr   = 1'b0;
    mem_we     = 1'b0;
    mem_waddr  = req_addr;
    mem_wdata  = req_data;
    rep_v_n    = 1'b0;
    rep_nak_n  = 1'b0;
    rep_dst_n  = req_src;
    rep_data_n = '0;
    coh_v_n    = 1'b0;
    coh_kind_n = CK_NONE;
    coh_mask_n = '0;
    coh_req_n  = req_src;
    fwd_v_n    = 1'b0;
    fwd_dst_n  = pend_req;
    fwd_data_n = rsp_data;

    // owner response completes the waiting transaction (R5, R6, R7)
    if (rsp_take) begin
      pend_clr = 1'b1;
      st_we    = 1'b1;
      st_waddr = pend_addr;
      if (pend_wr) begin
        st_wstate = DIR_EXC;
        st_wsh    = node_bit(pend_req);
      end else begin
        st_wstate = DIR_SHR;
        st_wsh    = node_bit(pend_req) | node_bit(pend_owner);
        mem_we    = 1'b1;
        mem_waddr = pend_addr;
        mem_wdata = rsp_data;
      end
      fwd_v_n = !pend_c2c;
    end

    if (nak) begin
      rep_v_n   = 1'b1;
      rep_nak_n = 1'b1;
    end else if (go) begin
      unique case (req_type)
        RQ_READ: begin
          if (need_owner) begin
            coh_v_n    = 1'b1;
            coh_kind_n = c2c_en ? CK_INTV_RD : CK_FETCH;
            coh_mask_n = node_bit(owner_idx);
            pend_set   = 1'b1;
          end else begin
            rep_v_n    = 1'b1;
            rep_data_n = mem_rdata;
            st_we      = 1'b1;
            st_wstate  = DIR_SHR;
            st_wsh     = cur_sharers | src_mask;
          end
        end
        RQ_WRITE: begin
          if (need_owner) begin
            coh_v_n    = 1'b1;
            coh_kind_n = c2c_en ? CK_INTV_WR : CK_FETCH_INV;
            coh_mask_n = node_bit(owner_idx);
            pend_set   = 1'b1;
          end else begin
            coh_v_n    = |inv_mask;
            coh_kind_n = CK_INV;
            coh_mask_n = inv_mask;
            rep_v_n    = 1'b1;
            rep_data_n = mem_rdata;
            st_we      = 1'b1;
            st_wstate  = DIR_EXC;
            st_wsh     = src_mask;
          end
        end
        RQ_WBACK: begin
          if (owned_by_src) begin
            mem_we    = 1'b1;
            mem_waddr = req_addr;
            mem_wdata = req_data;
            st_we     = 1'b1;
            st_wstate = DIR_UNC;
            st_wsh    = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_valid <= 1'b0;
      rep_nak   <= 1'b0;
      rep_dst   <= '0;
      rep_data  <= '0;
      coh_valid <= 1'b0;
      coh_kind  <= CK_NONE;
      coh_mask  <= '0;
      coh_addr  <= '0;
      coh_req   <= '0;
      fwd_valid <= 1'b0;
      fwd_dst   <= '0;
      fwd_addr  <= '0;
      fwd_data  <= '0;
    end else begin
      rep_valid <= rep_v_n;
      rep_nak   <= rep_nak_n;
      rep_dst   <= rep_dst_n;
      rep_data  <= rep_data_n;
      coh_valid <= coh_v_n;
      coh_kind  <= coh_kind_n;
      coh_mask  <= coh_mask_n;
      coh_addr  <= req_addr;
      coh_req   <= coh_req_n;
      fwd_valid <= fwd_v_n;
      fwd_dst   <= fwd_dst_n;
      fwd_addr  <= pend_addr;
      fwd_data  <= fwd_data_n;
    end
  end
endmodule

// File: rtl/dir_home_chk.sv
`timescale 1ns/1ps
module dir_home_chk #(
  parameter int NODES  = 8,
  parameter int NODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cur_state,
  input logic [NODES-1:0]  cur_sharers,
  input logic              pend_busy,
  input logic              rep_valid,
  input logic              rep_nak,
  input logic [NODE_W-1:0] rep_dst,
  input logic              coh_valid,
  input logic [2:0]        coh_kind,
  input logic [NODES-1:0]  coh_mask,
  input logic              fwd_valid
);
  // R1: an Uncached entry never lists sharers
  p_unc_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cur_state == 2'b00 |-> cur_sharers == '0);

  // R3: an Exclusive entry names exactly one owner
  p_excl_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cur_state == 2'b10 |-> $countones(cur_sharers) == 1);

  // R4: an invalidate is never empty and spares the node granted data
  p_inv_spares_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (coh_valid && coh_kind == 3'd1 && rep_valid && !rep_nak) |->
      (coh_mask != '0) && (((coh_mask >> rep_dst) & NODES'(1)) == '0));

  // R7: owner-directed messages target a single node and leave the home waiting
  p_owner_msg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (coh_valid && coh_kind != 3'd1) |-> ($countones(coh_mask) == 1) && pend_busy);

  // R5: forwarded data only ends a wait
  p_fwd_ends_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> !pend_busy && $past(pend_busy));

  // R9: the completion cycle never issues a new coherence message
  p_rsp_cycle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> !coh_valid);
endmodule

bind dir_home_ctrl dir_home_chk #(.NODES(NODES), .NODE_W(NODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cur_state(cur_state), .cur_sharers(cur_sharers), .pend_busy(pend_busy),
  .rep_valid(rep_valid), .rep_nak(rep_nak), .rep_dst(rep_dst),
  .coh_valid(coh_valid), .coh_kind(coh_kind), .coh_mask(coh_mask),
  .fwd_valid(fwd_valid)
);

// File: tb/dir_home_ctrl_bench.sv
`timescale 1ns/1ps
module dir_home_ctrl_bench;
  localparam int NODES = 8, NBLK = 16, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic c2c_en = 1'b0, req_valid = 1'b0, rsp_valid = 1'b0;
  logic [1:0] req_type = '0;
  logic [2:0] req_src = '0;
  logic [3:0] req_addr = '0;
  logic [DW-1:0] req_data = '0, rsp_data = '0;
  logic [3:0] mem_raddr, mem_waddr, coh_addr, fwd_addr;
  logic [DW-1:0] mem_rdata, mem_wdata, rep_data, fwd_data;
  logic mem_we, rep_valid, rep_nak, coh_valid, fwd_valid;
  logic [2:0] rep_dst, coh_kind, coh_req, fwd_dst;
  logic [7:0] coh_mask;

  always #2.5 clk = ~clk;

  dir_home_ctrl #(.NODES(NODES), .NBLK(NBLK), .DATA_W(DW)) u_dir_home_ctrl (
    .clk(clk), .rst_n(rst_n), .c2c_en(c2c_en),
    .req_valid(req_valid), .req_type(req_type), .req_src(req_src),
    .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .rep_valid(rep_valid), .rep_nak(rep_nak), .rep_dst(rep_dst), .rep_data(rep_data),
    .coh_valid(coh_valid), .coh_kind(coh_kind), .coh_mask(coh_mask),
    .coh_addr(coh_addr), .coh_req(coh_req),
    .fwd_valid(fwd_valid), .fwd_dst(fwd_dst), .fwd_addr(fwd_addr), .fwd_data(fwd_data)
  );

  // external memory model and an independent image of what it should hold
  logic [DW-1:0] bmem [NBLK];
  logic [DW-1:0] shadow [NBLK];
  initial for (int i = 0; i < NBLK; i++) begin
    bmem[i]   = 32'h1000_0000 | i;
    shadow[i] = 32'h1000_0000 | i;
  end
  always @(posedge clk) if (mem_we) bmem[mem_waddr] <= mem_wdata;
  assign mem_rdata = bmem[mem_raddr];

  function automatic logic [DW-1:0] wb_word(input int i);  return 32'hA000_0000 | i; endfunction
  function automatic logic [DW-1:0] rsp_word(input int i); return 32'hB000_0000 | i; endfunction

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic rv; logic [1:0] ty; logic [2:0] src; logic [3:0] addr; logic rsp; logic c2c;
    logic e_rep; logic e_nak; logic [2:0] e_dst;
    logic e_coh; logic [2:0] e_ck; logic [7:0] e_mask; logic [2:0] e_creq;
    logic e_fwd; logic [2:0] e_fdst; logic e_mw; logic [3:0] rq;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b1,2'd0,3'd1,4'd3,1'b0,1'b0, 1'b1,1'b0,3'd1, 1'b0,3'd0,8'h00,3'd0, 1'b0,3'd0,1'b0, 4'd2},  // R2 read U
    '{1'b1,2'd0,3'd2,4'd3,1'b0,1'b0, 1'b1,1'b0,3'd2, 1'b0,3'd0,8'h00,3'd0, 1'b0,3'd0,1'b0, 4'd2},  // R2 read S
    '{1'b1,2'd1,3'd2,4'd3,1'b0,1'b0, 1'b1,1'b0,3'd2, 1'b1,3'd1,8'h02,3'd0, 1'b0,3'd0,1'b0, 4'd4},  // R4 inv node1
    '{1'b1,2'd1,3'd5,4'd3,1'b0,1'b0, 1'b0,1'b0,3'd0, 1'b1,3'd3,8'h04,3'd0, 1'b0,3'd0,1'b0, 4'd5},  // R5 fetch-inv owner2
    '{1'b1,2'd0,3'd6,4'd3,1'b0,1'b0, 1'b1,1'b1,3'd6, 1'b0,3'd0,8'h00,3'd0, 1'b0,3'd0,1'b0, 4'd8},  // R8 busy block
    '{1'b1,2'd1,3'd7,4'd4,1'b0,1'b0, 1'b1,1'b0,3'd7, 1'b0,3'd0,8'h00,3'd0, 1'b0,3'd0,1'b0, 4'd3},  // R3 write U during wait
    '{1'b1,2'd0,3'd1,4'd4,1'b0,1'b0, 1'b1,1'b1,3'd1, 1'b0,3'd0,8'h00,3'd0, 1'b0,3'd0,1'b0, 4'd9},  // R9 second wait
    '{1'b1,2'd0,3'd0,4'd5,1'b1,1'b0, 1'b1,1'b1,3'd0, 1'b0,3'd0,8'h00,3'd0, 1'b1,3'd5,1'b0, 4'd9},  // R9 rsp cycle, R5 fwd
    '{1'b1,2'd0,3'd0,4'd3,1'b0,1'b0, 1'b0,1'b0,3'd0, 1'b1,3'd2,8'h20,3'd0, 1'b0,3'd0,1'b0, 4'd6},  // R6 fetch owner5
    '{1'b0,2'd0,3'd0,4'd3,1'b1,1'b0, 1'b0,1'b0,3'd0, 1'b0,3'd0,8'h00,3'd0, 1'b1,3'd0,1'b1, 4'd6},  // R6 complete
    '{1'b1,2'd0,3'd4,4'd3,1'b0,1'b0, 1'b1,1'b0,3'd4, 1'b0,3'd0,8'h00,3'd0, 1'b0,3'd0,1'b0, 4'd6},  // R6 memory updated
    '{1'b1,2'd1,3'd0,4'd3,1'b0,1'b0, 1'b1,1'b0,3'd0, 1'b1,3'd1,8'h30,3'd0, 1'b0,3'd0,1'b0, 4'd4},  // R4 inv {4,5}
    '{1'b1,2'd2,3'd3,4'd3,1'b0,1'b0, 1'b0,1'b0,3'd0, 1'b0,3'd0,8'h00,3'd0, 1'b0,3'd0,1'b0, 4'd10}, // R10 non-owner wb
    '{1'b1,2'd2,3'd0,4'd3,1'b0,1'b0, 1'b0,1'b0,3'd0, 1'b0,3'd0,8'h00,3'd0, 1'b0,3'd0,1'b1, 4'd10}, // R10 owner wb
    '{1'b1,2'd0,3'd6,4'd3,1'b0,1'b0, 1'b1,1'b0,3'd6, 1'b0,3'd0,8'h00,3'd0, 1'b0,3'd0,1'b0, 4'd10}, // R10 back to U
    '{1'b1,2'd1,3'd6,4'd3,1'b0,1'b0, 1'b1,1'b0,3'd6, 1'b0,3'd0,8'h00,3'd0, 1'b0,3'd0,1'b0, 4'd4},  // R4 empty mask
    '{1'b1,2'd0,3'd6,4'd3,1'b0,1'b0, 1'b1,1'b1,3'd6, 1'b0,3'd0,8'h00,3'd0, 1'b0,3'd0,1'b0, 4'd11}, // R11 owner re-miss
    '{1'b1,2'd3,3'd1,4'd3,1'b0,1'b0, 1'b0,1'b0,3'd0, 1'b0,3'd0,8'h00,3'd0, 1'b0,3'd0,1'b0, 4'd11}, // R11 reserved type
    '{1'b0,2'd0,3'd0,4'd3,1'b1,1'b0, 1'b0,1'b0,3'd0, 1'b0,3'd0,8'h00,3'd0, 1'b0,3'd0,1'b0, 4'd11}, // R11 stray rsp
    '{1'b1,2'd1,3'd1,4'd3,1'b0,1'b1, 1'b0,1'b0,3'd0, 1'b1,3'd5,8'h40,3'd1, 1'b0,3'd0,1'b0, 4'd7},  // R7 write intv
    '{1'b0,2'd0,3'd0,4'd3,1'b1,1'b1, 1'b0,1'b0,3'd0, 1'b0,3'd0,8'h00,3'd0, 1'b0,3'd0,1'b0, 4'd7},  // R7 done, no fwd
    '{1'b1,2'd0,3'd2,4'd3,1'b0,1'b1, 1'b0,1'b0,3'd0, 1'b1,3'd4,8'h02,3'd2, 1'b0,3'd0,1'b0, 4'd7},  // R7 read intv
    '{1'b0,2'd0,3'd0,4'd3,1'b1,1'b1, 1'b0,1'b0,3'd0, 1'b0,3'd0,8'h00,3'd0, 1'b0,3'd0,1'b1, 4'd7},  // R7 done, mem
    '{1'b1,2'd1,3'd3,4'd3,1'b0,1'b1, 1'b1,1'b0,3'd3, 1'b1,3'd1,8'h06,3'd0, 1'b0,3'd0,1'b0, 4'd4},  // R4 inv {1,2}
    '{1'b1,2'd2,3'd3,4'd3,1'b0,1'b1, 1'b0,1'b0,3'd0, 1'b0,3'd0,8'h00,3'd0, 1'b0,3'd0,1'b1, 4'd10}, // R10 owner wb
    '{1'b1,2'd0,3'd7,4'd4,1'b0,1'b0, 1'b1,1'b1,3'd7, 1'b0,3'd0,8'h00,3'd0, 1'b0,3'd0,1'b0, 4'd11}  // R11 owner re-miss
  };

  // present inputs for one clock edge; return at the following negedge
  task automatic step(input logic rv, input logic [1:0] ty, input logic [2:0] src,
                      input logic [3:0] addr, input logic rsp, input logic c2c, input int i);
    req_valid = rv; req_type = ty; req_src = src; req_addr = addr;
    req_data = wb_word(i); rsp_valid = rsp; rsp_data = rsp_word(i); c2c_en = c2c;
    @(negedge clk);
    req_valid = 1'b0; rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check(!rep_valid && !coh_valid && !fwd_valid, 1, "outputs idle after reset",
          {29'd0, rep_valid, coh_valid, fwd_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      step(v.rv, v.ty, v.src, v.addr, v.rsp, v.c2c, i);
      check(rep_valid == v.e_rep, v.rq, $sformatf("step %0d rep_valid", i), 32'(rep_valid), 32'(v.e_rep));
      if (v.e_rep) begin
        check(rep_nak == v.e_nak, v.rq, $sformatf("step %0d rep_nak", i), 32'(rep_nak), 32'(v.e_nak));
        check(rep_dst == v.e_dst, v.rq, $sformatf("step %0d rep_dst", i), 32'(rep_dst), 32'(v.e_dst));
        if (!v.e_nak)
          check(rep_data == shadow[v.addr], v.rq, $sformatf("step %0d rep_data", i), rep_data, shadow[v.addr]);
      end
      check(coh_valid == v.e_coh, v.rq, $sformatf("step %0d coh_valid", i), 32'(coh_valid), 32'(v.e_coh));
      if (v.e_coh) begin
        check(coh_kind == v.e_ck, v.rq, $sformatf("step %0d coh_kind", i), 32'(coh_kind), 32'(v.e_ck));
        check(coh_mask == v.e_mask, v.rq, $sformatf("step %0d coh_mask", i), 32'(coh_mask), 32'(v.e_mask));
        check(coh_addr == v.addr, v.rq, $sformatf("step %0d coh_addr", i), 32'(coh_addr), 32'(v.addr));
        if (v.e_ck >= 3'd4)
          check(coh_req == v.e_creq, v.rq, $sformatf("step %0d coh_req", i), 32'(coh_req), 32'(v.e_creq));
      end
      check(fwd_valid == v.e_fwd, v.rq, $sformatf("step %0d fwd_valid", i), 32'(fwd_valid), 32'(v.e_fwd));
      if (v.e_fwd) begin
        check(fwd_dst == v.e_fdst, v.rq, $sformatf("step %0d fwd_dst", i), 32'(fwd_dst), 32'(v.e_fdst));
        check(fwd_data == rsp_word(i), v.rq, $sformatf("step %0d fwd_data", i), fwd_data, rsp_word(i));
      end
      if (v.e_mw) shadow[v.addr] = (v.rv && v.ty == 2'd2) ? wb_word(i) : rsp_word(i);
      check(bmem[v.addr] == shadow[v.addr], v.rq, $sformatf("step %0d memory", i), bmem[v.addr], shadow[v.addr]);
    end

    // R1: reset clears an Exclusive entry
    step(1'b1, 2'd1, 3'd2, 4'd9, 1'b0, 1'b0, 100);
    check(rep_valid && !rep_nak, 3, "write miss to block 9", 32'(rep_valid), 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    check(!rep_valid && !coh_valid && !fwd_valid, 1, "outputs idle in reset",
          {29'd0, rep_valid, coh_valid, fwd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b1, 2'd1, 3'd4, 4'd9, 1'b0, 1'b0, 101);
    check(rep_valid && !rep_nak && rep_dst == 3'd4, 1, "write miss after reset served",
          {28'd0, rep_valid, rep_dst}, {28'd0, 1'b1, 3'd4});
    check(!coh_valid, 1, "no owner message after reset", 32'(coh_valid), 32'd0);
    check(rep_data == shadow[9], 1, "data after reset", rep_data, shadow[9]);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule